// File: doc/BRIEF.md
# Sequential Message Acceptance Filter Scanner

This block decides which stored message object, if any, should take a received frame. A pulse on `start_i` marks the moment the frame's identifier, extended-format flag and remote-request flag are complete. The block copies these fields into its own registers. It then reads a message-object RAM one entry per clock, starting at the lowest object and moving upward. Each entry is compared against the captured fields, and the walk ends at the first entry that accepts the frame.

When the walk ends, the block raises a one-cycle `done_o` pulse. Alongside it come a match flag, the 1-based number of the accepting object (zero when nothing accepted the frame), and that object's new-data and end-of-buffer flags for downstream handling. The RAM sits outside the block and returns the addressed word one clock after the read request. Because the read of the next object overlaps the compare of the current one, the block uses one RAM port and one comparator. The cost is a scan time that grows with the position of the hit.

Top module: `acc_filter_scan`

## Requirements
- R1: Each object word is 65 bits: [64] valid, [63] use-mask, [62] new-data, [61] end-of-buffer, [60] direction, [59] extended, [58:30] identifier, [29] mask-extended, [28:0] identifier mask. An object whose valid bit is 0 never accepts a frame.
- R2: Objects are examined from object 1 (RAM address 0) upward; the lowest-numbered accepting object wins and is reported as a 1-based index.
- R3: With use-mask 0, the object's extended bit must equal the frame's extended flag and every compared identifier bit must be equal; for a standard frame (extended flag 0) only identifier bits [28:18] are compared.
- R4: With use-mask 1, only identifier bits whose mask bit is 1 are compared, and the extended bit is compared only when mask-extended is 1.
- R5: A data frame (remote flag 0) is accepted only by objects with direction 0; a remote frame (remote flag 1) only by objects with direction 1.
- R6: One object is read per cycle, the first read in the cycle after start is sampled; a hit on object k raises done_o at the (k+2)-th rising edge, counting the edge that samples start as the first.
- R7: If no object accepts the frame, done_o rises at rising edge NUM_OBJ+2 with match_o 0 and index 0.
- R8: done_o is high for exactly one cycle; while done_o is low, match_o, the index and both flag outputs are 0.
- R9: The frame fields are latched at start, so later changes on those inputs do not affect the result; a start while a scan is running is ignored.
- R10: On a hit, the new-data and end-of-buffer bits of the accepting object appear on their outputs together with done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Frame fields complete; begin a scan |
| rx_id_i | input | 29 | Received identifier (standard identifiers in [28:18]) |
| rx_ext_i | input | 1 | Received frame uses the extended format |
| rx_rtr_i | input | 1 | Received frame is a remote frame |
| ram_rd_en_o | output | 1 | Object RAM read request |
| ram_addr_o | output | 5 | Object RAM address (object number minus 1) |
| ram_rdata_i | input | 65 | Object word, valid one cycle after the request |
| done_o | output | 1 | Scan finished (one-cycle pulse) |
| match_o | output | 1 | An object accepted the frame |
| obj_idx_o | output | 6 | 1-based number of the accepting object, 0 on a miss |
| hit_newdat_o | output | 1 | New-data bit of the accepting object |
| hit_eob_o | output | 1 | End-of-buffer bit of the accepting object |

## Verification
The bench loads one RAM image in which an invalid object and a duplicate entry sit in front of the real candidates. A design that ignores the valid bit, or keeps scanning past the first hit, would report the wrong index. Frames are sent that differ only in the remote flag, the extended flag, masked-off bits or the low identifier bits of a standard frame, so any mishandled don't-care or direction rule moves the hit to another object. The scan latency is counted for hits on the first, a middle and the last object and for a full miss. An off-by-one in the read pipeline therefore shows up as a wrong cycle count or a hit on the neighbouring object. A second start inside a running scan and changes to the frame inputs after start test the capture registers. A design without them would restart the walk, pulse done twice or match the wrong frame.

// File: rtl/acc_filter_pkg.sv
package acc_filter_pkg;

  localparam int ID_W = 29;
  localparam int STD_LSB = 18;

  typedef struct packed {
    logic            valid;
    logic            use_mask;
    logic            newdat;
    logic            eob;
    logic            dir;
    logic            ext;
    logic [ID_W-1:0] id;
    logic            mask_ext;
    logic [ID_W-1:0] id_mask;
  } obj_word_t;

  localparam int OBJ_W = $bits(obj_word_t);

  typedef enum logic {ST_IDLE = 1'b0, ST_SCAN = 1'b1} scan_state_t;

endpackage

// File: rtl/acc_filter_cmp.sv
module acc_filter_cmp
  import acc_filter_pkg::*;
(
  input  logic            valid,
  input  logic            use_mask,
  input  logic            dir,
  input  logic            ext,
  input  logic [ID_W-1:0] id,
  input  logic            mask_ext,
  input  logic [ID_W-1:0] id_mask,
  input  logic [ID_W-1:0] frm_id,
  input  logic            frm_ext,
  input  logic            frm_rtr,
  output logic            hit
);

  logic [ID_W-1:0] care;
  logic            ext_ok;
  logic            id_ok;

  always_comb begin
    care = use_mask ? id_mask : {ID_W{1'b1}};
    if (!frm_ext) begin
      care[STD_LSB-1:0] = '0;
    end
    ext_ok = (use_mask && !mask_ext) || (ext == frm_ext);
    id_ok  = ((id ^ frm_id) & care) == '0;
    hit    = valid && (dir == frm_rtr) && ext_ok && id_ok;
  end

endmodule

// File: rtl/acc_filter_walker.sv
module acc_filter_walker #(
  parameter int NUM_OBJ = 32,
  localparam int ADDR_W = $clog2(NUM_OBJ),
  localparam int CNT_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              stop,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              cmp_vld,
  output logic [ADDR_W-1:0] cmp_addr,
  output logic              cmp_last
);

  localparam logic [CNT_W-1:0]  END_CNT  = CNT_W'(NUM_OBJ);
  localparam logic [ADDR_W-1:0] LAST_ADR = ADDR_W'(NUM_OBJ - 1);

  logic              active_q, active_d;
  logic [CNT_W-1:0]  issue_q, issue_d;
  logic              vld_q, vld_d;
  logic [ADDR_W-1:0] caddr_q, caddr_d;

  assign rd_en    = active_q && (issue_q < END_CNT);
  assign rd_addr  = issue_q[ADDR_W-1:0];
  assign cmp_vld  = vld_q;
  assign cmp_addr = caddr_q;
  assign cmp_last = (caddr_q == LAST_ADR);

  always_comb begin
    active_d = active_q;
    issue_d  = issue_q;
    vld_d    = vld_q;
    caddr_d  = caddr_q;
    if (load) begin
      active_d = 1'b1;
      issue_d  = '0;
      vld_d    = 1'b0;
    end else if (stop) begin
      active_d = 1'b0;
      vld_d    = 1'b0;
    end else if (active_q) begin
      vld_d = rd_en;
      if (rd_en) begin
        issue_d = issue_q + 1'b1;
        caddr_d = issue_q[ADDR_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      issue_q  <= '0;
      vld_q    <= 1'b0;
      caddr_q  <= '0;
    end else begin
      active_q <= active_d;
      issue_q  <= issue_d;
      vld_q    <= vld_d;
      caddr_q  <= caddr_d;
    end
  end

endmodule

// File: rtl/acc_filter_scan.sv
module acc_filter_scan
  import acc_filter_pkg::*;
#(
  parameter int NUM_OBJ = 32,
  localparam int ADDR_W = $clog2(NUM_OBJ),
  localparam int IDX_W  = $clog2(NUM_OBJ + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ID_W-1:0]   rx_id_i,
  input  logic              rx_ext_i,
  input  logic              rx_rtr_i,
  output logic              ram_rd_en_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  input  logic [OBJ_W-1:0]  ram_rdata_i,
  output logic              done_o,
  output logic              match_o,
  output logic [IDX_W-1:0]  obj_idx_o,
  output logic              hit_newdat_o,
  output logic              hit_eob_o
);

  scan_state_t state_q, state_d;

  logic [ID_W-1:0] cap_id_q;
  logic            cap_ext_q;
  logic            cap_rtr_q;

  obj_word_t         obj;
  logic              load;
  logic              finish;
  logic              hit;
  logic              cmp_vld;
  logic              cmp_last;
  logic [ADDR_W-1:0] cmp_addr;

  logic             done_q, match_q, nd_q, eob_q;
  logic [IDX_W-1:0] idx_q;

  assign obj    = obj_word_t'(ram_rdata_i);
  assign load   = start_i && (state_q == ST_IDLE);
  assign finish = (state_q == ST_SCAN) && cmp_vld && (hit || cmp_last);

  acc_filter_walker #(.NUM_OBJ(NUM_OBJ)) u_walk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .stop     (finish),
    .rd_en    (ram_rd_en_o),
    .rd_addr  (ram_addr_o),
    .cmp_vld  (cmp_vld),
    .cmp_addr (cmp_addr),
    .cmp_last (cmp_last)
  );

  acc_filter_cmp u_cmp (
    .valid    (obj.valid),
    .use_mask (obj.use_mask),
    .dir      (obj.dir),
    .ext      (obj.ext),
    .id       (obj.id),
    .mask_ext (obj.mask_ext),
    .id_mask  (obj.id_mask),
    .frm_id   (cap_id_q),
    .frm_ext  (cap_ext_q),
    .frm_rtr  (cap_rtr_q),
    .hit      (hit)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (load)   state_d = ST_SCAN;
      ST_SCAN: if (finish) state_d = ST_IDLE;
      default:             state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_id_q  <= '0;
      cap_ext_q <= 1'b0;
      cap_rtr_q <= 1'b0;
    end else if (load) begin
      cap_id_q  <= rx_id_i;
      cap_ext_q <= rx_ext_i;
      cap_rtr_q <= rx_rtr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      match_q <= 1'b0;
      idx_q   <= '0;
      nd_q    <= 1'b0;
      eob_q   <= 1'b0;
    end else begin
      done_q  <= finish;
      match_q <= finish && hit;
      idx_q   <= (finish && hit) ? (IDX_W'(cmp_addr) + IDX_W'(1)) : '0;
      nd_q    <= finish && hit && obj.newdat;
      eob_q   <= finish && hit && obj.eob;
    end
  end

  assign done_o       = done_q;
  assign match_o      = match_q;
  assign obj_idx_o    = idx_q;
  assign hit_newdat_o = nd_q;
  assign hit_eob_o    = eob_q;

endmodule

// File: rtl/acc_filter_scan_chk.sv
module acc_filter_scan_chk #(
  parameter int NUM_OBJ = 32,
  localparam int ADDR_W = $clog2(NUM_OBJ),
  localparam int IDX_W  = $clog2(NUM_OBJ + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              ram_rd_en_o,
  input logic [ADDR_W-1:0] ram_addr_o,
  input logic              done_o,
  input logic              match_o,
  input logic [IDX_W-1:0]  obj_idx_o,
  input logic              hit_newdat_o,
  input logic              hit_eob_o
);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  quiet_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> (!match_o && obj_idx_o == '0 && !hit_newdat_o && !hit_eob_o));

  // R2
  hit_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> (obj_idx_o != '0 && obj_idx_o <= IDX_W'(NUM_OBJ)));

  // R7
  miss_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !match_o) |-> (obj_idx_o == '0));

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_rd_en_o && $past(ram_rd_en_o)) |->
      (ram_addr_o == ADDR_W'($past(ram_addr_o) + 1'b1)));

  // R9
  scan_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_rd_en_o) |-> ($past(start_i) && ram_addr_o == '0));

endmodule

bind acc_filter_scan acc_filter_scan_chk #(.NUM_OBJ(NUM_OBJ)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .ram_rd_en_o  (ram_rd_en_o),
  .ram_addr_o   (ram_addr_o),
  .done_o       (done_o),
  .match_o      (match_o),
  .obj_idx_o    (obj_idx_o),
  .hit_newdat_o (hit_newdat_o),
  .hit_eob_o    (hit_eob_o)
);

// File: tb/acc_filter_scan_test.sv
`timescale 1ns/1ps
module acc_filter_scan_test;

  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [28:0] rx_id_i = '0;
  logic        rx_ext_i = 1'b0;
  logic        rx_rtr_i = 1'b0;
  logic        ram_rd_en_o;
  logic [4:0]  ram_addr_o;
  logic [64:0] ram_rdata_i;
  logic        done_o, match_o, hit_newdat_o, hit_eob_o;
  logic [5:0]  obj_idx_o;

  logic [64:0] mem [N];

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk) begin
    if (ram_rd_en_o) ram_rdata_i <= mem[ram_addr_o];
  end

  acc_filter_scan #(.NUM_OBJ(N)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rx_id_i(rx_id_i),
    .rx_ext_i(rx_ext_i), .rx_rtr_i(rx_rtr_i), .ram_rd_en_o(ram_rd_en_o),
    .ram_addr_o(ram_addr_o), .ram_rdata_i(ram_rdata_i), .done_o(done_o),
    .match_o(match_o), .obj_idx_o(obj_idx_o), .hit_newdat_o(hit_newdat_o),
    .hit_eob_o(hit_eob_o)
  );

  // Layout per R1: valid,use_mask,newdat,eob,dir,ext,id[29],mask_ext,mask[29]
  function automatic logic [64:0] mk(input logic v, input logic um, input logic nd,
                                     input logic eb, input logic dr, input logic ex,
                                     input logic [28:0] id, input logic mx,
                                     input logic [28:0] mk_bits);
    return {v, um, nd, eb, dr, ex, id, mx, mk_bits};
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load_image();
    for (int i = 0; i < N; i++) mem[i] = '0;
    mem[0]  = mk(0, 0, 0, 0, 0, 1, 29'h1234567, 0, '0);          // invalid twin of obj2
    mem[1]  = mk(1, 0, 0, 0, 0, 1, 29'h1234567, 0, '0);
    mem[2]  = mk(1, 0, 0, 0, 0, 1, 29'h1234567, 0, '0);          // duplicate
    mem[4]  = mk(1, 1, 1, 1, 0, 1, 29'h0ABCDE00, 1, 29'h1FFFFF00);
    mem[7]  = mk(1, 0, 0, 0, 1, 1, 29'h00FF00F, 0, '0);
    mem[9]  = mk(1, 0, 0, 0, 0, 0, {11'h123, 18'h0}, 0, '0);
    mem[11] = mk(1, 1, 0, 0, 0, 0, 29'h0, 0, '0);                // any data frame
    mem[31] = mk(1, 0, 0, 0, 1, 0, {11'h7FF, 18'h0}, 0, '0);
  endtask

  // Launch a scan; n counts rising edges from the one sampling start (first = 1)
  task automatic run(input logic [28:0] id, input logic ex, input logic rt,
                     output int n);
    @(negedge clk);
    rx_id_i = id; rx_ext_i = ex; rx_rtr_i = rt; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    rx_id_i = ~id; rx_ext_i = ~ex; rx_rtr_i = ~rt;   // R9: inputs change after start
    n = 1;
    while (!done_o && n < 80) begin
      @(negedge clk);
      n++;
    end
  endtask

  // {id, ext, rtr, match, idx, flags}
  localparam logic [38:0] VEC [9] = '{
    {29'h1234567,        1'b1, 1'b0, 1'b1, 6'd2,  1'b0},  // R1 R2 R3
    {29'h0ABCDE37,       1'b1, 1'b0, 1'b1, 6'd5,  1'b1},  // R4 R10
    {29'h0ABCDE37,       1'b0, 1'b0, 1'b1, 6'd12, 1'b0},  // R4 mask_ext
    {{11'h123, 18'h3FFFF}, 1'b0, 1'b0, 1'b1, 6'd10, 1'b0},// R3 standard
    {29'h00FF00F,        1'b1, 1'b1, 1'b1, 6'd8,  1'b0},  // R5 remote
    {29'h00FF00F,        1'b1, 1'b0, 1'b1, 6'd12, 1'b0},  // R5 data
    {{11'h7FF, 18'h0},   1'b0, 1'b1, 1'b1, 6'd32, 1'b0},  // R6 last
    {29'h1234567,        1'b1, 1'b1, 1'b0, 6'd0,  1'b0},  // R7 miss
    {{11'h123, 18'h0},   1'b1, 1'b0, 1'b1, 6'd12, 1'b0}   // R3 ext compare
  };

  initial begin
    int n;
    load_image();
    repeat (3) @(negedge clk);
    chk("R8 reset done", done_o, 0);
    chk("R8 reset match", match_o, 0);
    chk("R6 reset rd_en", ram_rd_en_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    foreach (VEC[v]) begin
      logic [38:0] e;
      int exp_n;
      e = VEC[v];
      run(e[38:10], e[9], e[8], n);
      exp_n = e[7] ? int'(e[6:1]) + 2 : N + 2;
      chk("R6 latency", n, exp_n);
      chk("R2 match", match_o, e[7]);
      chk("R2 index", obj_idx_o, e[6:1]);
      chk("R10 newdat", hit_newdat_o, e[0]);
      chk("R10 eob", hit_eob_o, e[0]);
      @(negedge clk);
      chk("R8 pulse", done_o, 0);
      chk("R8 idle index", obj_idx_o, 0);
    end

    // R9: second start during a running scan (miss frame) is ignored
    begin
      int cnt;
      int dones;
      @(negedge clk);
      rx_id_i = 29'h1234567; rx_ext_i = 1'b1; rx_rtr_i = 1'b1; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      n = 1;
      dones = 0;
      cnt = 0;
      while (!done_o && n < 80) begin
        @(negedge clk);
        n++;
        if (n == 5) begin
          rx_rtr_i = 1'b0; start_i = 1'b1;   // would hit obj2 if accepted
        end else begin
          start_i = 1'b0;
        end
      end
      chk("R9 ignored start latency", n, N + 2);
      chk("R9 ignored start match", match_o, 0);
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (done_o) dones++;
        if (ram_rd_en_o) cnt++;
      end
      chk("R9 no second scan", dones + cnt, 0);
    end

    // R1: all objects invalid -> miss even though words match
    for (int i = 0; i < N; i++) mem[i][64] = 1'b0;
    run(29'h1234567, 1'b1, 1'b0, n);
    chk("R1 invalid miss", match_o, 0);
    chk("R7 miss latency", n, N + 2);
    chk("R7 miss index", obj_idx_o, 0);

    // R2: first object accepts
    load_image();
    mem[0][64] = 1'b1;
    run(29'h1234567, 1'b1, 1'b0, n);
    chk("R2 first object", obj_idx_o, 1);
    chk("R6 first latency", n, 3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule